// File: doc/BRIEF.md
# Latch-or-Register Bus Driver

This block moves an N-bit data word (18 bits unless set otherwise) from input `a_i` to output `y_o` through a single storage stage, using one of three behaviours. With the latch-enable input high, the stage is transparent and `y_o` follows `a_i`. With latch-enable low, the stage acts as an edge-triggered register. It loads `a_i` when the bus clock rises and keeps its value for as long as the bus clock stays at a steady level.

An active-low output enable decides whether the word is driven. Instead of a true three-state pin, the block presents a data vector and a per-bit drive-enable vector of the same width. Drive-enable low on a bit means that bit is released (high impedance), and the data vector then reads zero. The output enable acts only on these two vectors and never on the stored word.

The bus clock and latch-enable arrive asynchronously. Each passes through a two-flop synchronizer into the fast system clock domain. A bus clock rising edge is recognised as a low-then-high pair of successive synchronized samples.

Top module: `lrbd_bus_driver`

## Requirements
- R1: While `oe_n_i` is 1, every bit of `drive_en_o` is 0 and `y_o` reads all zeros, whatever the other inputs are.
- R2: While `oe_n_i` is 0 and reset is released, every bit of `drive_en_o` is 1.
- R3: Once synchronized latch-enable is high, `y_o` equals `a_i` combinationally: an `a_i` change shows up on `y_o` in the same system clock cycle.
- R4: With latch-enable low, a rising bus clock loads the current `a_i` into the stage, and that value is driven on `y_o`.
- R5: With latch-enable low and the bus clock held steady (high or low), `y_o` keeps its value while `a_i` changes.
- R6: When latch-enable falls, including while the bus clock is high, the stage keeps the last value seen during transparency.
- R7: Deasserting and then reasserting the output enable leaves the stored word unchanged, so `y_o` again shows the word held before the outputs were disabled.
- R8: During reset both `y_o` and `drive_en_o` are zero. After reset the stored word is zero.
- R9: A bus clock rise applied just after a system clock edge changes `y_o` on the third following system clock edge. A latch-enable rise makes `y_o` follow `a_i` from the second following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus controls |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_clk_i | input | 1 | Asynchronous bus clock; its rising edge loads the stage |
| latch_en_i | input | 1 | Asynchronous latch-enable; high selects the transparent mode |
| oe_n_i | input | 1 | Active-low output enable |
| a_i | input | DATA_W | Data input word |
| y_o | output | DATA_W | Data output word; zero while released |
| drive_en_o | output | DATA_W | Per-bit drive enable; 0 means the bit is in high impedance |

## Verification
The bench targets the points where a latch and a register behave differently. It closes latch-enable while the bus clock is high and then changes `a_i`: a design that waited for another clock edge, or kept tracking the input, would show the new input instead of the last transparent value. It also changes `a_i` while the bus clock sits steady at both levels, and toggles the output enable on its own. A design that captured on levels or on falling edges, or cleared its store when released, would then show a changed or zeroed word. Exact latency checks around each synchronizer catch a missing or extra pipeline stage.

// File: rtl/lrbd_pkg.sv
package lrbd_pkg;
  typedef enum logic {
    PATH_HOLD = 1'b0,
    PATH_PASS = 1'b1
  } path_mode_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/lrbd_rst_sync.sv
module lrbd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lrbd_sync.sv
module lrbd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/lrbd_store.sv
module lrbd_store
  import lrbd_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  path_mode_e        mode_i,
  input  logic              bclk_s_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] view_o
);
  logic              bclk_prev_q;
  logic              bclk_rise;
  logic              held_en;
  logic [DATA_W-1:0] held_q;
  logic [DATA_W-1:0] held_d;

  assign bclk_rise = bclk_s_i & ~bclk_prev_q;

  always_comb begin
    held_en = 1'b0;
    held_d  = held_q;
    unique case (mode_i)
      PATH_PASS: held_en = 1'b1;
      PATH_HOLD: held_en = bclk_rise;
      default:   held_en = 1'b0;
    endcase
    if (held_en) begin
      held_d = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev_q <= 1'b0;
      held_q      <= '0;
    end else begin
      bclk_prev_q <= bclk_s_i;
      if (held_en) begin
        held_q <= held_d;
      end
    end
  end

  assign view_o = (mode_i == PATH_PASS) ? d_i : held_q;

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PATH_HOLD && !bclk_rise) |=> $stable(held_q));

  a_r4_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PATH_HOLD && bclk_rise) |=> (held_q == $past(d_i)));

  a_r6_track_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PATH_PASS) |=> (held_q == $past(d_i)));
endmodule

// File: rtl/lrbd_drive.sv
module lrbd_drive #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              rst_n,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] view_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] en_o
);
  logic drive_on;

  assign drive_on = ~oe_n_i & rst_n;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign en_o[b]   = drive_on;
    assign data_o[b] = drive_on & view_i[b];
  end
endmodule

// File: rtl/lrbd_bus_driver.sv
module lrbd_bus_driver
  import lrbd_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk_i,
  input  logic              latch_en_i,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] drive_en_o
);
  localparam int unsigned CTRL_W = 2;

  logic              rst_n_int;
  logic [CTRL_W-1:0] ctrl_async;
  logic [CTRL_W-1:0] ctrl_sync;
  path_mode_e        mode;
  logic [DATA_W-1:0] view;

  lrbd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  assign ctrl_async = {latch_en_i, bus_clk_i};

  lrbd_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .async_i (ctrl_async),
    .sync_o  (ctrl_sync)
  );

  assign mode = ctrl_sync[1] ? PATH_PASS : PATH_HOLD;

  lrbd_store #(.DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .mode_i   (mode),
    .bclk_s_i (ctrl_sync[0]),
    .d_i      (a_i),
    .view_o   (view)
  );

  lrbd_drive #(.DATA_W(DATA_W)) u_drive (
    .rst_n  (rst_n_int),
    .oe_n_i (oe_n_i),
    .view_i (view),
    .data_o (y_o),
    .en_o   (drive_en_o)
  );

  a_r1_released_is_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    oe_n_i |-> (drive_en_o == '0 && y_o == '0));

  a_r3_open_follows_input: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mode == PATH_PASS && !oe_n_i) |-> (y_o == a_i));

  a_r2_all_bits_driven: assert property (@(posedge clk) disable iff (!rst_n_int)
    !oe_n_i |-> ($countones(drive_en_o) == DATA_W));
endmodule

// File: tb/lrbd_bus_driver_tb_top.sv
module lrbd_bus_driver_tb_top;
  localparam int unsigned W = 18;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_clk;
  logic         le;
  logic         oe_n;
  logic [W-1:0] a;
  logic [W-1:0] y;
  logic [W-1:0] en;

  int unsigned checks = 0;
  int unsigned errors = 0;

  logic [W-1:0] m_held;

  always #2 clk = ~clk;

  lrbd_bus_driver #(.DATA_W(W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_clk_i  (bus_clk),
    .latch_en_i (le),
    .oe_n_i     (oe_n),
    .a_i        (a),
    .y_o        (y),
    .drive_en_o (en)
  );

  function automatic logic [W-1:0] exp_y(logic oe_nf, logic lef, logic [W-1:0] af, logic [W-1:0] hf);
    if (oe_nf) return '0;
    return lef ? af : hf;
  endfunction

  function automatic logic [W-1:0] exp_en(logic oe_nf);
    return oe_nf ? '0 : ONES;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic chk_model(string req);
    #1;
    chk(req, y, exp_y(oe_n, le, a, m_held));
    chk(req, en, exp_en(oe_n));
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_clk = 1'b0; le = 1'b0; oe_n = 1'b0; a = 18'h2A5C3;
    m_held = '0;
    void'($urandom(32'h5EED_0042));
    cyc(3); #1;
    chk("R8 y in reset", y, '0);
    chk("R8 en in reset", en, '0);
    @(negedge clk); rst_n = 1'b1;
    cyc(4);
    chk_model("R8 stored zero after reset");
    chk("R2 all bits driven", en, ONES);

    // R4 capture and R9 latency
    @(negedge clk); a = 18'h1F0F0; bus_clk = 1'b1;
    cyc(1); #1; chk("R9 rise edge1 old", y, '0);
    cyc(1); #1; chk("R9 rise edge2 old", y, '0);
    cyc(1); #1; chk("R9 rise edge3 new", y, 18'h1F0F0);
    m_held = 18'h1F0F0;
    cyc(2); a = 18'h00777; cyc(4);
    chk_model("R5 steady high hold");
    bus_clk = 1'b0; cyc(4); a = 18'h3C3C3; cyc(4);
    chk_model("R5 steady low hold");
    bus_clk = 1'b1; cyc(5); m_held = a;
    chk_model("R4 captured on rise");

    // R3 transparent, with R9 latch-enable latency
    bus_clk = 1'b0; a = 18'h12345; le = 1'b1;
    cyc(1); #1; chk("R9 le edge1 still held", y, 18'h3C3C3);
    cyc(1); #1; chk("R3 le edge2 follows", y, 18'h12345);
    @(negedge clk); a = 18'h2BEEF; #1;
    chk("R3 same-cycle follow", y, 18'h2BEEF);
    m_held = a;

    // R6 close with bus clock high
    bus_clk = 1'b1; cyc(4); a = 18'h0ACE1; m_held = a; cyc(4);
    le = 1'b0; cyc(4); a = 18'h3FFFF; cyc(3);
    chk_model("R6 last transparent value kept");
    chk("R6 explicit", y, 18'h0ACE1);

    // R1 and R7
    oe_n = 1'b1; cyc(2); chk_model("R1 released");
    oe_n = 1'b0; cyc(1); oe_n = 1'b1; cyc(1); oe_n = 1'b0; cyc(1);
    chk_model("R7 toggle keeps word");
    chk("R7 explicit", y, 18'h0ACE1);

    // Random operation mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom_range(0, 3);
      @(negedge clk);
      case (op)
        0: begin a = W'($urandom); if (le) m_held = a; end
        1: begin le = ~le; if (!le) m_held = a; end
        2: begin bus_clk = ~bus_clk; if (bus_clk && !le) m_held = a; end
        default: oe_n = ~oe_n;
      endcase
      cyc(5);
      case (op)
        0: chk_model("R3/R5 random data");
        1: chk_model("R6 random latch-enable");
        2: chk_model("R4 random bus clock");
        default: chk_model("R1/R7 random enable");
      endcase
    end
    finish_run();
  end
endmodule